// File: doc/BRIEF.md
# Station-Address PROM Signature Scanner

This block hunts for a fixed eight-byte marker in a station-address PROM. The PROM has a read pointer that advances by itself after every read. A single start pulse launches a run. The block first issues a throw-away read, which resets the PROM pointer. It then reads one byte that decides whether to raise an address-counter enable control bit. After that it pulls bytes one at a time and tracks how far into the marker the stream has progressed.

The scan is bounded. It gives up after the probe length plus the marker length minus one bytes. When the last marker byte matches, no further read is issued. This leaves the PROM pointer on the first station-address byte, ready for a later readout.

Each read uses a request/valid handshake. The request stays high until the PROM returns valid. The result is a one-cycle done pulse together with a found flag, which holds its value until the next accepted start.

Top module: `prom_sig_finder`

## Requirements
- R1: After reset, rd_req_o, done_o, found_o and cnt_en_o are all low.
- R2: An accepted start produces exactly one discarded read, then one arming read, then the scan reads. Over a run the PROM sees 2 plus the number of scanned bytes read handshakes.
- R3: cnt_en_o is set when the arming byte equals 8'h08. It stays clear for any other arming value, and it is cleared by each accepted start.
- R4: The marker is 8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA in read order. When its eighth byte is accepted, the done pulse follows with found_o high, and rd_req_o is low from the next cycle on.
- R5: A scanned byte that breaks a partial match restarts the match position at 1 if the byte is 8'hFF, and at 0 otherwise.
- R6: At most PROBE_LEN+7 bytes (39 by default) are scanned. A marker completing on the last window byte reports found. Otherwise the run ends after that byte with found_o low.
- R7: done_o is high for exactly one cycle per run. found_o changes only with that pulse or with an accepted start, which clears it.
- R8: A start pulse while a run is in progress is ignored.
- R9: A byte counts only in a cycle where rd_req_o and rd_valid_i are both high. While valid is low the request is held and the scan state does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| rd_req_o | output | 1 | PROM byte-read request, held until valid |
| rd_valid_i | input | 1 | PROM byte valid, completes one read |
| rd_data_i | input | 8 | PROM byte |
| cnt_en_o | output | 1 | Address-counter enable control bit |
| done_o | output | 1 | One-cycle end-of-run pulse |
| found_o | output | 1 | Marker located; held until next start |

## Verification
The marker match and the expiry of the scan window can land on the same accepted byte. That byte is then both the eighth marker byte and the last byte of the window. To provoke it, the bench places the marker behind exactly 31 filler bytes, so it completes on byte 39. It expects found with 41 PROM reads. A second stream shifts the marker by one filler byte. For that stream the bench expects not-found after exactly 39 scanned bytes, which shows that expiry cuts the match short, and no 42nd read.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int SIG_LEN = 8;
  localparam int IDX_W   = $clog2(SIG_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_ARM,
    ST_SCAN
  } psf_state_e;

  // Marker byte at a given position: the four-byte cell repeats twice.
  function automatic logic [7:0] sig_byte(input logic [IDX_W-1:0] pos);
    logic [7:0] b;
    case (pos[1:0])
      2'd0:    b = 8'hFF;
      2'd1:    b = 8'h00;
      2'd2:    b = 8'h55;
      default: b = 8'hAA;
    endcase
    return b;
  endfunction

  // Match position after one byte, with the restart rule on mismatch.
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] cur,
                                                 input logic [7:0]       b);
    logic [IDX_W-1:0] n;
    if (b == sig_byte(cur))
      n = cur + 1'b1;
    else if (b == sig_byte('0))
      n = IDX_W'(1);
    else
      n = '0;
    return n;
  endfunction
endpackage

// File: rtl/psf_matcher.sv
module psf_matcher
  import psf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [7:0]       byte_i,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic [IDX_W-1:0] idx_nx;

  assign idx_nx = next_idx(idx, byte_i);
  assign hit    = step && (idx_nx == IDX_W'(SIG_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      idx <= '0;
    else if (step)
      idx <= idx_nx;
  end
endmodule

// File: rtl/psf_window.sv
module psf_window #(
  parameter int WIN = 39,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = step && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (step)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prom_sig_finder.sv
module prom_sig_finder
  import psf_pkg::*;
#(
  parameter int         PROBE_LEN = 32,
  parameter logic [7:0] ARM_BYTE  = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       rd_req_o,
  input  logic       rd_valid_i,
  input  logic [7:0] rd_data_i,
  output logic       cnt_en_o,
  output logic       done_o,
  output logic       found_o
);
  localparam int WIN_LEN = PROBE_LEN + SIG_LEN - 1;
  localparam int CW      = $clog2(WIN_LEN + 1);

  psf_state_e state, state_nx;

  // Named events, shared with the checker.
  logic             busy;
  logic             acc;
  logic             start_acc;
  logic             scan_acc;
  logic             hit;
  logic             last;
  logic             finish;
  logic [IDX_W-1:0] idx;
  logic [CW-1:0]    win_cnt;

  assign busy      = (state != ST_IDLE);
  assign rd_req_o  = busy;
  assign acc       = rd_req_o && rd_valid_i;
  assign start_acc = start_i && !busy;
  assign scan_acc  = acc && (state == ST_SCAN);
  assign finish    = hit || last;

  psf_matcher u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_acc),
    .step   (scan_acc),
    .byte_i (rd_data_i),
    .idx    (idx),
    .hit    (hit)
  );

  psf_window #(.WIN(WIN_LEN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc),
    .step  (scan_acc),
    .cnt   (win_cnt),
    .last  (last)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start_acc) state_nx = ST_FLUSH;
      ST_FLUSH: if (acc)       state_nx = ST_ARM;
      ST_ARM:   if (acc)       state_nx = ST_SCAN;
      ST_SCAN:  if (scan_acc && finish) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done_o   <= 1'b0;
      found_o  <= 1'b0;
      cnt_en_o <= 1'b0;
    end else begin
      state  <= state_nx;
      done_o <= scan_acc && finish;
      if (start_acc)
        found_o <= 1'b0;
      else if (scan_acc && hit)
        found_o <= 1'b1;
      if (start_acc)
        cnt_en_o <= 1'b0;
      else if (acc && state == ST_ARM && rd_data_i == ARM_BYTE)
        cnt_en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/prom_sig_finder_chk.sv
module prom_sig_finder_chk
  import psf_pkg::*;
#(
  parameter int         PROBE_LEN = 32,
  parameter logic [7:0] ARM_BYTE  = 8'h08,
  localparam int WIN_LEN = PROBE_LEN + SIG_LEN - 1,
  localparam int CW      = $clog2(WIN_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rd_req_o,
  input logic             rd_valid_i,
  input logic [7:0]       rd_data_i,
  input logic             cnt_en_o,
  input logic             done_o,
  input logic             found_o,
  input logic             busy,
  input logic             scan_acc,
  input logic             hit,
  input logic             last,
  input logic [IDX_W-1:0] idx,
  input logic [CW-1:0]    win_cnt
);
  a_r3_arm_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en_o) |-> ($past(rd_data_i) == ARM_BYTE && $past(rd_valid_i)));

  a_r4_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_acc && hit) |=> (!rd_req_o && done_o && found_o));

  a_r5_restart_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_acc && rd_data_i != sig_byte(idx) && rd_data_i == 8'hFF) |=> (idx == IDX_W'(1)));

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_acc && rd_data_i != sig_byte(idx) && rd_data_i != 8'hFF) |=> (idx == '0));

  a_r6_window_cap: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(WIN_LEN));

  a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_acc && last && !hit) |=> (done_o && !found_o && !rd_req_o));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(found_o) |-> (done_o || $past(start_i)));

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ((busy || done_o) && ($stable(found_o) || done_o)));

  a_r9_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_valid_i) |=> ($stable(win_cnt) && $stable(idx) && rd_req_o));
endmodule

bind prom_sig_finder prom_sig_finder_chk #(
  .PROBE_LEN (PROBE_LEN),
  .ARM_BYTE  (ARM_BYTE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .rd_data_i  (rd_data_i),
  .cnt_en_o   (cnt_en_o),
  .done_o     (done_o),
  .found_o    (found_o),
  .busy       (busy),
  .scan_acc   (scan_acc),
  .hit        (hit),
  .last       (last),
  .idx        (idx),
  .win_cnt    (win_cnt)
);

// File: tb/prom_sig_finder_test.sv
module prom_sig_finder_test;
  localparam int WIN = 39;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       rd_req_o;
  logic       rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic       cnt_en_o;
  logic       done_o;
  logic       found_o;

  prom_sig_finder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .cnt_en_o   (cnt_en_o),
    .done_o     (done_o),
    .found_o    (found_o)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // PROM model: serves rom[] with a programmable gap before each valid.
  logic [7:0] rom[$];
  logic [7:0] stim[$];
  int ptr = 0;
  int reads = 0;
  int gap = 0;
  int lat = 0;

  always @(posedge clk) begin
    if (start_i && !rd_req_o) begin
      ptr   <= 0;
      reads <= 0;
    end else if (rd_req_o && rd_valid_i) begin
      ptr   <= ptr + 1;
      reads <= reads + 1;
    end
    if (!rd_req_o || rd_valid_i) gap <= lat;
    else if (gap > 0)            gap <= gap - 1;
  end

  always @(negedge clk) begin
    rd_valid_i = rd_req_o && (gap == 0);
    rd_data_i  = (ptr < rom.size()) ? rom[ptr] : 8'h11;
  end

  // Scoreboard.
  typedef struct {
    int found;
    int en;
    int nreads;
    int id;
  } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk($sformatf("R4/R6 found case %0d", e.id), int'(found_o), e.found);
        chk($sformatf("R3 cnt_en case %0d", e.id), int'(cnt_en_o), e.en);
        chk($sformatf("R2 read count case %0d", e.id), reads, e.nreads);
      end
    end
  end

  // Reference: a marker is looked up in a table, position moves per byte.
  logic [7:0] marker [8] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA};

  task automatic run_case(input int id, input logic [7:0] first, input int lat_v,
                          input bit mid_start);
    exp_t e;
    int   pos = 0;
    int   used = 0;
    rom.delete();
    rom.push_back(8'h5A);
    rom.push_back(first);
    foreach (stim[k]) rom.push_back(stim[k]);
    while (pos < 8 && used < WIN) begin
      logic [7:0] b;
      b = (used < stim.size()) ? stim[used] : 8'h11;
      used++;
      if (b == marker[pos]) pos++;
      else if (b == 8'hFF)  pos = 1;   // R5 restart on first marker byte
      else                  pos = 0;   // R5 restart at zero
    end
    e.found  = (pos == 8) ? 1 : 0;
    e.en     = (first == 8'h08) ? 1 : 0;
    e.nreads = 2 + used;
    e.id     = id;
    exp_q.push_back(e);
    lat = lat_v;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R7 found cleared by start", int'(found_o), 0);
    chk("R3 cnt_en cleared by start", int'(cnt_en_o), 0);
    if (mid_start) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;                 // R8 ignored while busy
      @(negedge clk); start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk("R7 done one cycle", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk("R4 no request after end", int'(rd_req_o), 0);
    chk("R4 no extra reads", reads, e.nreads);
    chk("R7 found held", int'(found_o), e.found);
  endtask

  task automatic add_sig();
    foreach (marker[k]) stim.push_back(marker[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_req reset", int'(rd_req_o), 0);
    chk("R1 done reset", int'(done_o), 0);
    chk("R1 found reset", int'(found_o), 0);
    chk("R1 cnt_en reset", int'(cnt_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Case 1: plain hit after three fillers, arming byte matches (R3, R4).
    stim.delete();
    stim.push_back(8'h12); stim.push_back(8'h34); stim.push_back(8'h00);
    add_sig();
    run_case(1, 8'h08, 0, 1'b0);

    // Case 2: break on FF restarts at 1 (R5), slow PROM (R9).
    stim.delete();
    stim = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00};
    add_sig();
    run_case(2, 8'h00, 2, 1'b0);

    // Case 3: break on a non-FF byte restarts at 0 (R5).
    stim.delete();
    stim = '{8'hFF, 8'h00, 8'h55, 8'h12};
    add_sig();
    run_case(3, 8'h07, 1, 1'b0);

    // Case 4: marker completes on the last window byte (R6).
    stim.delete();
    for (int k = 0; k < 31; k++) stim.push_back(8'h3C);
    add_sig();
    run_case(4, 8'h08, 0, 1'b0);

    // Case 5: marker one byte too late, window expires (R6).
    stim.delete();
    for (int k = 0; k < 32; k++) stim.push_back(8'h3C);
    add_sig();
    run_case(5, 8'h08, 1, 1'b0);

    // Case 6: stream of FF only never matches (R5, R6).
    stim.delete();
    for (int k = 0; k < 45; k++) stim.push_back(8'hFF);
    run_case(6, 8'h09, 0, 1'b0);

    // Case 7: start while busy is ignored (R8).
    stim.delete();
    for (int k = 0; k < 20; k++) stim.push_back(8'h00);
    add_sig();
    run_case(7, 8'h08, 1, 1'b1);

    chk("R8 no leftover result", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule